// File: doc/BRIEF.md
# Mode-Selectable Bus Priority Arbiter

This block shares one bus port among the four traffic sources of a video decoder: the input stream reader, the reference picture reader, the decoder output writer and the post-processor output writer. Each source raises a request and waits for its grant. Once it is granted, it keeps the bus for a whole transaction and marks the final beat with its last line. Request and grant work as a valid/ready pair. A source must hold its request until its grant arrives or it withdraws. The arbiter never removes a grant in the middle of a transaction except when the request itself is dropped.

A 3-bit mode input selects the ordering that resolves contention. Four modes fix the ordering, and each of them names one source or a pair of sources at the top. The remaining mode lets a 2-bit hint input choose the top source, so the ordering can follow the content being decoded. Sources that a mode does not name fall in below the named ones in the default order: input read, reference read, decoder write, post-processor write.

Top module: `vdec_bus_arbiter`

## Requirements
- R1: Requester indices are 0 = input stream read, 1 = reference read, 2 = decoder output write and 3 = post-processor write, and bit i of req_i, last_i and gnt_o belongs to requester i. At most one gnt_o bit is high at any time. A grant goes only to a requester whose request was high. When the bus is idle and a request is present, the grant appears at the next rising clock edge, and with no request no grant appears.
- R2: With mode 1 the priority order, highest first, is 3, 0, 1, 2.
- R3: With mode 2 the priority order is 0, 1, 2, 3.
- R4: With mode 3 the priority order is 1, 3, 0, 2.
- R5: With mode 4 the priority order is 1, 2, 0, 3.
- R6: With mode 0 the requester whose index equals hint_i is highest. The other three follow in the order 0, 1, 2, 3.
- R7: Mode values 5, 6 and 7 behave exactly as mode 0.
- R8: While a grant is active and its requester keeps req high with last low, the grant is held. Other requests and any change of mode_i or hint_i have no effect on it.
- R9: When the granted requester has last high at a clock edge, its grant is low after that edge. The following cycle is idle, and a new grant to a pending requester appears one edge later, decided by the mode and hint present in that idle cycle.
- R10: When the granted requester drops req, its grant is low after the next clock edge.
- R11: While rst_n is low, all grants are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Priority mode select |
| hint_i | input | 2 | Content hint: index of the top requester in mode 0 |
| req_i | input | 4 | Per-requester bus request |
| last_i | input | 4 | Per-requester final-beat marker |
| gnt_o | output | 4 | Per-requester grant, at most one high |

## Verification
The arbitration choice is swept over every mode value, every hint value and all fifteen non-empty request patterns, starting from idle. This distinguishes each fixed ordering, shows that the hint moves only the top position, and shows that the high mode values map onto the dynamic mode. Directed sequences then apply a flood of competing requests and a mode change during a held grant, which separates holding from re-arbitration. They also release the grant with last or by withdrawing the request, to check the single idle cycle and the choice that follows it.

// File: rtl/vba_pkg.sv
package vba_pkg;
  localparam int NREQ  = 4;
  localparam int IDX_W = $clog2(NREQ);

  typedef logic [IDX_W-1:0] req_idx_t;

  localparam req_idx_t RQ_IN  = 2'd0;
  localparam req_idx_t RQ_REF = 2'd1;
  localparam req_idx_t RQ_DEC = 2'd2;
  localparam req_idx_t RQ_PP  = 2'd3;
endpackage

// File: rtl/vba_order_gen.sv
module vba_order_gen
  import vba_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0]           mode_i,
  input  req_idx_t                    hint_i,
  output logic [NREQ-1:0][IDX_W-1:0]  order_o
);
  int slot;

  always_comb begin
    order_o = '0;
    slot    = 1;
    case (mode_i)
      MODE_W'(1): begin
        order_o[0] = RQ_PP;  order_o[1] = RQ_IN;
        order_o[2] = RQ_REF; order_o[3] = RQ_DEC;
      end
      MODE_W'(2): begin
        order_o[0] = RQ_IN;  order_o[1] = RQ_REF;
        order_o[2] = RQ_DEC; order_o[3] = RQ_PP;
      end
      MODE_W'(3): begin
        order_o[0] = RQ_REF; order_o[1] = RQ_PP;
        order_o[2] = RQ_IN;  order_o[3] = RQ_DEC;
      end
      MODE_W'(4): begin
        order_o[0] = RQ_REF; order_o[1] = RQ_DEC;
        order_o[2] = RQ_IN;  order_o[3] = RQ_PP;
      end
      default: begin
        order_o[0] = hint_i;
        for (int k = 0; k < NREQ; k++) begin
          if (IDX_W'(k) != hint_i) begin
            order_o[slot] = IDX_W'(k);
            slot = slot + 1;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/vba_pick.sv
module vba_pick
  import vba_pkg::*;
(
  input  logic [NREQ-1:0]             req_i,
  input  logic [NREQ-1:0][IDX_W-1:0]  order_i,
  output logic                        any_o,
  output req_idx_t                    sel_o
);
  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    for (int p = NREQ - 1; p >= 0; p--) begin
      if (req_i[order_i[p]]) begin
        any_o = 1'b1;
        sel_o = order_i[p];
      end
    end
  end
endmodule

// File: rtl/vdec_bus_arbiter.sv
module vdec_bus_arbiter
  import vba_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        hint_i,
  input  logic [NREQ-1:0]   req_i,
  input  logic [NREQ-1:0]   last_i,
  output logic [NREQ-1:0]   gnt_o
);
  logic [NREQ-1:0][IDX_W-1:0] order;
  logic                       any_req;
  req_idx_t                   winner;
  logic [NREQ-1:0]            gnt_q, gnt_d, release_vec;
  logic                       busy;

  vba_order_gen #(.MODE_W(MODE_W)) u_order (
    .mode_i (mode_i),
    .hint_i (hint_i),
    .order_o(order)
  );

  vba_pick u_pick (
    .req_i  (req_i),
    .order_i(order),
    .any_o  (any_req),
    .sel_o  (winner)
  );

  assign busy = |gnt_q;

  for (genvar i = 0; i < NREQ; i++) begin : g_rel
    assign release_vec[i] = gnt_q[i] & (~req_i[i] | last_i[i]);

    // R10: withdrawn request loses grant at next edge
    a_r10_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_q[i] && !req_i[i] |=> !gnt_q[i]);
    // R9: last ends the grant
    a_r9_last_release: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_q[i] && last_i[i] |=> !gnt_q[i]);
    // R8: grant kept until last
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_q[i] && req_i[i] && !last_i[i] |=> gnt_q[i]);
    // R1: new grant only to a requester
    a_r1_granted_requested: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_q[i]) |-> $past(req_i[i]));
  end

  always_comb begin
    gnt_d = gnt_q;
    if (busy) begin
      if (|release_vec) gnt_d = '0;
    end else if (any_req) begin
      gnt_d = NREQ'(1) << winner;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= '0;
    else        gnt_q <= gnt_d;
  end

  assign gnt_o = gnt_q;

  // R1: never two grants
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  // R9: grant moves between requesters only through an idle cycle
  a_r9_via_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$stable(gnt_q) |-> $past(gnt_q) == '0);
endmodule

// File: tb/test_vdec_bus_arbiter.sv
module test_vdec_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic [1:0] hint = '0;
  logic [3:0] req = '0;
  logic [3:0] last = '0;
  logic [3:0] gnt;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vdec_bus_arbiter i_vdec_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .hint_i(hint),
    .req_i(req), .last_i(last), .gnt_o(gnt)
  );

  function automatic int exp_pick(int m, int h, logic [3:0] r);
    int ord[4];
    int s;
    case (m)
      1: begin ord[0]=3; ord[1]=0; ord[2]=1; ord[3]=2; end
      2: begin ord[0]=0; ord[1]=1; ord[2]=2; ord[3]=3; end
      3: begin ord[0]=1; ord[1]=3; ord[2]=0; ord[3]=2; end
      4: begin ord[0]=1; ord[1]=2; ord[2]=0; ord[3]=3; end
      default: begin
        ord[0] = h; s = 1;
        for (int k = 0; k < 4; k++) if (k != h) begin ord[s] = k; s++; end
      end
    endcase
    for (int p = 0; p < 4; p++) if (r[ord[p]]) return ord[p];
    return -1;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gnt=%b expected=%b (mode=%0d hint=%0d req=%b)",
               tag, act, exp, mode, hint, req);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    int w;
    @(negedge clk);
    req = 4'b1111;
    step();
    check("R11", gnt, 4'b0000);
    @(negedge clk); req = '0; rst_n = 1'b1;
    step();
    check("R1", gnt, 4'b0000);

    // exhaustive sweep over mode, hint and request pattern
    for (int m = 0; m < 8; m++) begin
      for (int h = 0; h < 4; h++) begin
        for (int r = 1; r < 16; r++) begin
          case (m)
            0: tag = "R6"; 1: tag = "R2"; 2: tag = "R3";
            3: tag = "R4"; 4: tag = "R5"; default: tag = "R7";
          endcase
          mode = 3'(m); hint = 2'(h); req = 4'(r);
          w = exp_pick(m, h, 4'(r));
          step();
          check(tag, gnt, 4'b1 << w);
          last = 4'b1 << w;
          step();
          check("R9", gnt, 4'b0000);
          req = '0; last = '0;
          step();
        end
      end
    end

    // R8: hold under competition and mode change
    mode = 3'd2; req = 4'b0001;
    step();
    check("R8", gnt, 4'b0001);
    req = 4'b1111; mode = 3'd1; hint = 2'd2;
    for (int c = 0; c < 4; c++) begin
      step();
      check("R8", gnt, 4'b0001);
    end
    // R9: last, idle cycle, then new mode decides
    last = 4'b0001;
    step();
    check("R9", gnt, 4'b0000);
    last = '0;
    step();
    check("R9", gnt, 4'b1000);
    // R10: withdraw request
    req = 4'b0111;
    step();
    check("R10", gnt, 4'b0000);
    step();
    check("R10", gnt, 4'b0001);
    mode = 3'd6; hint = 2'd3; req = 4'b1110;
    step();
    check("R10", gnt, 4'b0000);
    step();
    check("R7", gnt, 4'b1000);
    req = '0;
    step();
    check("R10", gnt, 4'b0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule